// File: doc/BRIEF.md
# Queued I2C Write Command Engine

The engine takes a write command that a host assembles in a small byte-indexed buffer and turns it into an I2C write on a dedicated controller port. The command carries a 7-bit target address, a payload length, a register offset and up to ten payload bytes. When the host pulses the command strobe, the engine checks the command. It then either puts a copy into a four-entry transaction queue or refuses it. In both cases it answers with a return code on the next cycle.

A bit-level controller drains the queue in arrival order. It drives the open-drain SCL and SDA lines through pull-low enables. Each transaction is START, address with the write bit, offset, payload, then STOP. The ACK bit after every byte is checked. A target that does not acknowledge ends its transaction early and raises a sticky interrupt flag.

Success means only that the command was queued. After an accepted command, a lockout window of a parameterised number of cycles refuses any new command. The default corresponds to five seconds at 50 MHz.

Top module: `i2cw_engine`

## Requirements
- R1: Buffer index 1 bits 6:0 hold the target address, and bit 7 is ignored. Index 4 holds the register offset. Indices 5 to 14 hold payload bytes 0 to 9. A write to index 0, to index 3, or to an index above 14 changes nothing that is sent.
- R2: Index 2 is the payload byte count, and index 3 is a reserved high length byte that is ignored. A count of 0 or of more than 10 is rejected and nothing is queued. Any count from 1 to 10 is accepted.
- R3: Exactly one cycle after a cycle with `cmd_go_i` high, `rsp_valid_o` is high for one cycle, and it is low at all other times. `rsp_code_o` is 0x00 for queued and 0x03 for rejected. A queued command can be answered with 0x00 while earlier transactions are still on the bus.
- R4: The queue holds 4 entries in addition to the transaction being sent. A command that arrives while the queue is full is rejected. Transactions are sent in the order they were accepted.
- R5: A command sampled fewer than LOCK_CYC cycles after the last accepted command is rejected. One sampled exactly LOCK_CYC cycles later may be accepted. Rejected commands do not restart the window.
- R6: Each transaction is START, then {address, 0}, the offset and `count` payload bytes, each sent MSB first and each followed by an ACK bit, then STOP. SDA changes only while SCL is low, except at START and STOP.
- R7: When the ACK bit of a byte reads high (NACK), the engine issues STOP right after that byte. It drops the rest of that transaction and moves on to the next queue entry.
- R8: `nack_irq_o` is set by any NACK and stays set until `irq_clr_i` is high for a cycle. If a NACK and a clear happen in the same cycle, the set wins.
- R9: After reset, both pull-low enables are 0 (lines released), `rsp_valid_o` is 0 and `nack_irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| buf_we_i | input | 1 | Command buffer byte write strobe |
| buf_idx_i | input | IDX_W | Buffer byte index, counted from 1 |
| buf_wdata_i | input | 8 | Buffer write data |
| cmd_go_i | input | 1 | Issue the command held in the buffer |
| rsp_valid_o | output | 1 | Return code valid, one cycle after `cmd_go_i` |
| rsp_code_o | output | 8 | Return code: 0x00 queued, 0x03 rejected |
| irq_clr_i | input | 1 | Clear the NACK interrupt flag |
| nack_irq_o | output | 1 | Sticky target-NACK flag |
| scl_oe_o | output | 1 | Pull SCL low when 1 |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| sda_i | input | 1 | Sensed SDA line level |

## Verification
The bench goes after four corner cases:

- **Lockout edges.** It sends one command a cycle before the lockout window closes and another exactly at its end. A counter that is off by one, or that a rejection restarts, refuses the second command.
- **Length limits.** It sends counts of 0, 10 and 11. It also writes junk to index 0 and to every index from 15 to 31 before a ten-byte send. A decoder that folds high indices into the payload would put wrong bytes on the bus.
- **Queue filling.** It fills the queue behind a long transfer until a command is refused. A queue one entry too shallow or too deep moves that refusal.
- **NACK handling.** It makes the target refuse the address byte and the offset byte, with other commands queued behind them. An engine that keeps sending after a NACK, or stalls, breaks the byte count between START and STOP. A flag that is not sticky reads low after the bus goes idle.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
  localparam int MAX_PAY = 10;
  localparam int LEN_W   = 4;

  localparam logic [7:0] RC_OK  = 8'h00;
  localparam logic [7:0] RC_REJ = 8'h03;

  typedef struct packed {
    logic [6:0]               addr;
    logic [7:0]               off;
    logic [LEN_W-1:0]         len;
    logic [MAX_PAY-1:0][7:0]  pay;
  } wr_cmd_t;

  typedef enum logic [1:0] {
    BUS_IDLE,
    BUS_START,
    BUS_BIT,
    BUS_STOP
  } bus_st_e;
endpackage

// File: rtl/i2cw_cmd_buf.sv
module i2cw_cmd_buf
  import i2cw_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [7:0]       wdata_i,
  output wr_cmd_t          cmd_o,
  output logic [7:0]       len_o
);
  localparam int PAY_BASE = 5;

  logic [6:0] addr_q;
  logic [7:0] len_q;
  logic [7:0] off_q;
  logic [7:0] pay_q [MAX_PAY];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      len_q  <= '0;
      off_q  <= '0;
      for (int i = 0; i < MAX_PAY; i++) pay_q[i] <= '0;
    end else if (we_i) begin
      // index 3 (reserved length high byte) and anything past the payload is dropped
      if (idx_i == IDX_W'(1)) addr_q <= wdata_i[6:0];
      if (idx_i == IDX_W'(2)) len_q  <= wdata_i;
      if (idx_i == IDX_W'(4)) off_q  <= wdata_i;
      for (int i = 0; i < MAX_PAY; i++)
        if (idx_i == IDX_W'(PAY_BASE + i)) pay_q[i] <= wdata_i;
    end
  end

  always_comb begin
    cmd_o.addr = addr_q;
    cmd_o.off  = off_q;
    cmd_o.len  = len_q[LEN_W-1:0];
    for (int i = 0; i < MAX_PAY; i++) cmd_o.pay[i] = pay_q[i];
  end

  assign len_o = len_q;
endmodule

// File: rtl/i2cw_fifo.sv
module i2cw_fifo #(
  parameter type T     = logic,
  parameter int  DEPTH = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic push_i,
  input  T     data_i,
  input  logic pop_i,
  output T     data_o,
  output logic empty_o,
  output logic full_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  T                 mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;

  logic do_push, do_pop;
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + CNT_W'(1);
      else if (do_pop && !do_push) cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign data_o  = mem_q[rd_q];
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
endmodule

// File: rtl/i2cw_bus_ctrl.sv
module i2cw_bus_ctrl
  import i2cw_pkg::*;
#(
  parameter int QTR_CYC = 125
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    q_empty_i,
  input  wr_cmd_t q_data_i,
  output logic    q_pop_o,
  input  logic    sda_i,
  output logic    scl_oe_o,
  output logic    sda_oe_o,
  output logic    nack_o
);
  localparam int DIV_W = $clog2(QTR_CYC + 1);

  bus_st_e          state_q;
  logic [1:0]       ph_q;
  logic [3:0]       bit_q;
  logic [3:0]       byte_q;
  logic             nack_q;
  logic [DIV_W-1:0] div_q;
  wr_cmd_t          cmd_q;

  logic       tick;
  logic       last_byte;
  logic [7:0] cur_byte;
  logic [3:0] pay_idx;

  assign tick      = (state_q != BUS_IDLE) && (div_q == DIV_W'(QTR_CYC - 1));
  assign last_byte = (byte_q == cmd_q.len + 4'd1);
  assign pay_idx   = byte_q - 4'd2;
  assign q_pop_o   = (state_q == BUS_IDLE) && !q_empty_i;

  always_comb begin
    if (byte_q == 4'd0)      cur_byte = {cmd_q.addr, 1'b0};
    else if (byte_q == 4'd1) cur_byte = cmd_q.off;
    else                     cur_byte = cmd_q.pay[pay_idx];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else if (state_q == BUS_IDLE || tick) div_q <= '0;
    else div_q <= div_q + DIV_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= BUS_IDLE;
      ph_q    <= '0;
      bit_q   <= '0;
      byte_q  <= '0;
      nack_q  <= 1'b0;
      nack_o  <= 1'b0;
      cmd_q   <= '0;
    end else begin
      nack_o <= 1'b0;
      unique case (state_q)
        BUS_IDLE: if (!q_empty_i) begin
          cmd_q   <= q_data_i;
          state_q <= BUS_START;
          ph_q    <= '0;
        end
        BUS_START: if (tick) begin
          ph_q <= ph_q + 2'd1;
          if (ph_q == 2'd3) begin
            state_q <= BUS_BIT;
            bit_q   <= '0;
            byte_q  <= '0;
          end
        end
        BUS_BIT: if (tick) begin
          ph_q <= ph_q + 2'd1;
          if (ph_q == 2'd1 && bit_q == 4'd8) nack_q <= sda_i;
          if (ph_q == 2'd3) begin
            if (bit_q != 4'd8) begin
              bit_q <= bit_q + 4'd1;
            end else if (nack_q || last_byte) begin
              state_q <= BUS_STOP;
              nack_o  <= nack_q;
            end else begin
              byte_q <= byte_q + 4'd1;
              bit_q  <= '0;
            end
          end
        end
        BUS_STOP: if (tick) begin
          ph_q <= ph_q + 2'd1;
          if (ph_q == 2'd3) state_q <= BUS_IDLE;
        end
        default: state_q <= BUS_IDLE;
      endcase
    end
  end

  // phase 0/3: SCL low, 1/2: SCL high
  always_comb begin
    scl_oe_o = 1'b0;
    sda_oe_o = 1'b0;
    unique case (state_q)
      BUS_IDLE: ;
      BUS_START: begin
        sda_oe_o = (ph_q != 2'd0);
        scl_oe_o = ph_q[1];
      end
      BUS_BIT: begin
        scl_oe_o = (ph_q == 2'd0) || (ph_q == 2'd3);
        sda_oe_o = !bit_q[3] && !cur_byte[~bit_q[2:0]];
      end
      BUS_STOP: begin
        scl_oe_o = (ph_q == 2'd0);
        sda_oe_o = !ph_q[1];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/i2cw_engine.sv
module i2cw_engine
  import i2cw_pkg::*;
#(
  parameter int QTR_CYC  = 125,
  parameter int LOCK_CYC = 250_000_000,
  parameter int Q_DEPTH  = 4,
  parameter int IDX_W    = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             buf_we_i,
  input  logic [IDX_W-1:0] buf_idx_i,
  input  logic [7:0]       buf_wdata_i,
  input  logic             cmd_go_i,
  output logic             rsp_valid_o,
  output logic [7:0]       rsp_code_o,
  input  logic             irq_clr_i,
  output logic             nack_irq_o,
  output logic             scl_oe_o,
  output logic             sda_oe_o,
  input  logic             sda_i
);
  localparam int LK_W = $clog2(LOCK_CYC + 1);

  wr_cmd_t    buf_cmd, q_head;
  logic [7:0] len_q;
  logic       q_full, q_empty, q_pop;
  logic       len_ok, lock_busy, acc_w;
  logic       nack_pulse;
  logic [LK_W-1:0] lock_q;

  i2cw_cmd_buf #(.IDX_W(IDX_W)) u_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (buf_we_i),
    .idx_i   (buf_idx_i),
    .wdata_i (buf_wdata_i),
    .cmd_o   (buf_cmd),
    .len_o   (len_q)
  );

  assign len_ok    = (len_q != 8'd0) && (len_q <= 8'(MAX_PAY));
  assign lock_busy = (lock_q != '0);
  assign acc_w     = cmd_go_i && len_ok && !q_full && !lock_busy;

  i2cw_fifo #(.T(wr_cmd_t), .DEPTH(Q_DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (acc_w),
    .data_i  (buf_cmd),
    .pop_i   (q_pop),
    .data_o  (q_head),
    .empty_o (q_empty),
    .full_o  (q_full)
  );

  i2cw_bus_ctrl #(.QTR_CYC(QTR_CYC)) u_bus (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .q_empty_i (q_empty),
    .q_data_i  (q_head),
    .q_pop_o   (q_pop),
    .sda_i     (sda_i),
    .scl_oe_o  (scl_oe_o),
    .sda_oe_o  (sda_oe_o),
    .nack_o    (nack_pulse)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lock_q <= '0;
    else if (acc_w) lock_q <= LK_W'(LOCK_CYC - 1);
    else if (lock_busy) lock_q <= lock_q - LK_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_code_o  <= RC_OK;
      nack_irq_o  <= 1'b0;
    end else begin
      rsp_valid_o <= cmd_go_i;
      if (cmd_go_i) rsp_code_o <= acc_w ? RC_OK : RC_REJ;
      if (nack_pulse)     nack_irq_o <= 1'b1;
      else if (irq_clr_i) nack_irq_o <= 1'b0;
    end
  end
endmodule

// File: rtl/i2cw_engine_chk.sv
module i2cw_engine_chk
  import i2cw_pkg::*;
#(
  parameter int LOCK_CYC = 250_000_000
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cmd_go_i,
  input logic       rsp_valid_o,
  input logic [7:0] rsp_code_o,
  input logic       irq_clr_i,
  input logic       nack_irq_o,
  input logic       acc_i,
  input logic [7:0] len_i,
  input logic       q_full_i
);
  localparam int G_W = $clog2(LOCK_CYC + 1);

  logic [G_W-1:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gap_q <= G_W'(LOCK_CYC);
    else if (acc_i) gap_q <= G_W'(1);
    else if (gap_q != G_W'(LOCK_CYC)) gap_q <= gap_q + G_W'(1);
  end

  a_r3_rsp_follows_go: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_go_i |=> rsp_valid_o);

  a_r3_no_rsp_without_go: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_go_i |=> !rsp_valid_o);

  a_r3_code_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rsp_code_o == RC_OK || rsp_code_o == RC_REJ));

  a_r2_len_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i |-> (len_i != 8'd0 && len_i <= 8'(MAX_PAY)));

  a_r4_no_push_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i |-> !q_full_i);

  a_r5_lockout: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i |-> (gap_q == G_W'(LOCK_CYC)));

  a_r8_irq_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nack_irq_o && !irq_clr_i) |=> nack_irq_o);
endmodule

bind i2cw_engine i2cw_engine_chk #(.LOCK_CYC(LOCK_CYC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_go_i    (cmd_go_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_code_o  (rsp_code_o),
  .irq_clr_i   (irq_clr_i),
  .nack_irq_o  (nack_irq_o),
  .acc_i       (acc_w),
  .len_i       (len_q),
  .q_full_i    (q_full)
);

// File: tb/i2cw_engine_bench.sv
module i2cw_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LOCK = 24;
  localparam int QTR  = 2;

  logic       clk = 1'b0;
  logic       rst_ni;
  logic       buf_we;
  logic [4:0] buf_idx;
  logic [7:0] buf_wdata;
  logic       cmd_go;
  logic       irq_clr;
  logic       rsp_valid;
  logic [7:0] rsp_code;
  logic       nack_irq;
  logic       scl_oe, sda_oe;
  logic       tgt_pull = 1'b0;
  logic       scl_line, sda_line;

  assign scl_line = !scl_oe;
  assign sda_line = !sda_oe && !tgt_pull;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2cw_engine #(.QTR_CYC(QTR), .LOCK_CYC(LOCK)) u_i2cw_engine (
    .clk_i(clk), .rst_ni(rst_ni), .buf_we_i(buf_we), .buf_idx_i(buf_idx),
    .buf_wdata_i(buf_wdata), .cmd_go_i(cmd_go), .rsp_valid_o(rsp_valid),
    .rsp_code_o(rsp_code), .irq_clr_i(irq_clr), .nack_irq_o(nack_irq),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .sda_i(sda_line)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] exp_bytes[$];
  int         exp_cnt[$];
  int         exp_nack[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pay_of(input logic [7:0] seed, input int i);
    return seed + 8'(i * 29);
  endfunction

  // scoreboard monitor / target model
  logic p_scl = 1'b1, p_sda = 1'b1;
  bit   in_xfer = 0;
  int   bitcnt = 0, bytecnt = 0, cur_nack = -1;
  logic [7:0] sh = '0;

  always @(scl_line or sda_line) begin
    if (scl_line === 1'b1 && p_scl === 1'b0) begin
      if (in_xfer) begin
        if (bitcnt < 8) sh = {sh[6:0], sda_line};
        bitcnt++;
        if (bitcnt == 8) begin
          if (exp_bytes.size() == 0) check(0, "R6 unexpected byte", sh, 0);
          else begin
            logic [7:0] e;
            e = exp_bytes.pop_front();
            check(sh == e, "R6 byte", sh, e);
          end
        end else if (bitcnt == 9) begin
          bitcnt = 0;
          bytecnt++;
        end
      end
    end else if (scl_line === 1'b0 && p_scl === 1'b1) begin
      if (in_xfer && bitcnt == 8) tgt_pull = (bytecnt != cur_nack);
      else tgt_pull = 1'b0;
    end else if (scl_line === 1'b1 && sda_line !== p_sda) begin
      if (sda_line === 1'b0) begin
        if (exp_nack.size() == 0) begin
          check(0, "R4 unexpected START", 1, 0);
          cur_nack = -1;
        end else cur_nack = exp_nack.pop_front();
        in_xfer = 1; bitcnt = 0; bytecnt = 0;
      end else if (sda_line === 1'b1 && in_xfer) begin
        in_xfer = 0;
        if (exp_cnt.size() != 0) begin
          int c;
          c = exp_cnt.pop_front();
          check(bytecnt == c, "R7 bytes before STOP", bytecnt, c);
        end
        bitcnt = 0;
      end
    end
    p_scl = scl_line;
    p_sda = sda_line;
  end

  task automatic wr(input int idx, input logic [7:0] d);
    buf_we = 1'b1; buf_idx = 5'(idx); buf_wdata = d;
    @(negedge clk);
    buf_we = 1'b0;
  endtask

  task automatic load(input logic [7:0] a, input logic [7:0] len, input logic [7:0] len_hi,
                      input logic [7:0] off, input logic [7:0] seed);
    wr(1, a); wr(2, len); wr(3, len_hi); wr(4, off);
    for (int i = 0; i < 10; i++) wr(5 + i, pay_of(seed, i));
  endtask

  task automatic go(input bit exp_ok, input string req, input logic [6:0] a, input int len,
                    input logic [7:0] off, input logic [7:0] seed, input int nack_at);
    cmd_go = 1'b1;
    @(negedge clk);
    cmd_go = 1'b0;
    check(rsp_valid == 1'b1, {req, " R3 rsp_valid"}, rsp_valid, 1);
    check(rsp_code == (exp_ok ? 8'h00 : 8'h03), {req, " R3 code"}, rsp_code, exp_ok ? 0 : 3);
    if (exp_ok) begin
      int n;
      n = (nack_at < 0) ? len + 2 : nack_at + 1;
      for (int i = 0; i < n; i++)
        exp_bytes.push_back(i == 0 ? {a, 1'b0} : i == 1 ? off : pay_of(seed, i - 2));
      exp_cnt.push_back(n);
      exp_nack.push_back(nack_at);
    end
  endtask

  task automatic drain();
    while (exp_cnt.size() != 0) @(negedge clk);
    repeat (20) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      check(0, "watchdog", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; buf_we = 0; buf_idx = 0; buf_wdata = 0; cmd_go = 0; irq_clr = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check(scl_oe == 0 && sda_oe == 0, "R9 lines released", {scl_oe, sda_oe}, 0);
    check(rsp_valid == 0, "R9 rsp_valid", rsp_valid, 0);
    check(nack_irq == 0, "R9 irq", nack_irq, 0);

    // R1 R2: reserved bits, max length, stray indices
    load(8'hD2, 8'd10, 8'hFF, 8'h10, 8'h40);
    wr(0, 8'hEE);
    for (int i = 15; i < 32; i++) wr(i, 8'hA5);
    go(1, "R1 R2 max len", 7'h52, 10, 8'h10, 8'h40, -1);
    drain();
    check(nack_irq == 0, "R8 no nack yet", nack_irq, 0);

    // R2: zero and oversize counts rejected, nothing on bus
    wr(2, 8'd0);
    go(0, "R2 len0", 7'h52, 0, 8'h10, 8'h40, -1);
    wr(2, 8'd11);
    go(0, "R2 len11", 7'h52, 11, 8'h10, 8'h40, -1);
    repeat (200) @(negedge clk);
    check(exp_cnt.size() == 0 && !in_xfer, "R2 rejected not sent", in_xfer, 0);

    // R7 R4: NACK on offset, next entries continue in order
    load(8'h21, 8'd1, 8'h00, 8'h33, 8'h05);
    go(1, "R7 nack offset", 7'h21, 1, 8'h33, 8'h05, 1);
    load(8'h22, 8'd2, 8'h00, 8'h44, 8'h77);
    repeat (LOCK) @(negedge clk);
    go(1, "R4 fifo second", 7'h22, 2, 8'h44, 8'h77, -1);
    load(8'h23, 8'd3, 8'h00, 8'h55, 8'h19);
    repeat (LOCK) @(negedge clk);
    go(1, "R7 nack addr", 7'h23, 3, 8'h55, 8'h19, 0);
    drain();
    check(nack_irq == 1, "R8 irq set", nack_irq, 1);
    repeat (50) @(negedge clk);
    check(nack_irq == 1, "R8 irq sticky", nack_irq, 1);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    check(nack_irq == 0, "R8 irq cleared", nack_irq, 0);

    // R5: lockout edges, rejected command does not restart window
    load(8'h30, 8'd2, 8'h00, 8'h01, 8'h90);
    repeat (LOCK) @(negedge clk);
    go(1, "R5 first", 7'h30, 2, 8'h01, 8'h90, -1);
    repeat (LOCK - 2) @(negedge clk);
    go(0, "R5 one cycle early", 7'h30, 2, 8'h01, 8'h90, -1);
    go(1, "R5 at window end", 7'h30, 2, 8'h01, 8'h90, -1);
    drain();

    // R4: fill queue behind a long transfer
    load(8'h3C, 8'd10, 8'h00, 8'hC3, 8'h11);
    repeat (LOCK) @(negedge clk);
    for (int k = 0; k < 5; k++) begin
      go(1, "R4 fill", 7'h3C, 10, 8'hC3, 8'h11, -1);
      repeat (LOCK - 1) @(negedge clk);
    end
    go(0, "R4 full reject", 7'h3C, 10, 8'hC3, 8'h11, -1);
    drain();
    check(exp_bytes.size() == 0, "R6 all bytes seen", exp_bytes.size(), 0);
    check(nack_irq == 0, "R8 no spurious irq", nack_irq, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule